// File: doc/BRIEF.md
# Clock-source wake-up delay timer

This block keeps the core clock enable low after a start or wake event until the selected oscillator has had time to settle. How long it waits depends on the clock source. The crystal ranges need a count of oscillator cycles followed by an absolute settling window. The internal RC oscillator needs only an absolute window. The watchdog oscillator and the external clock input need only a short cycle count.

The block runs on the raw oscillator clock. A free-running reference strobe of known period, one cycle wide and synchronous to that clock, measures the absolute windows in ticks. Two parameters set the tick counts so that each window lands inside its allowed range. With a 1 µs tick, the default 70 sits inside 60–100 µs and the default 230 sits inside 200–300 µs.

A start pulse samples the select code, clears both counters and begins a wait. The block asserts a registered ready flag when the wait ends. The clock-enable output follows ready, but it drops in the same cycle that a new start pulse is present.

Top module: `wkup_delay_timer`

## Requirements
- R1: During reset and after reset release, `ready_o` and `clk_en_o` are 0, and they stay 0 until a started wait completes.
- R2: The select code decodes as follows. Codes 0, 1 and 2 are the low, medium and high crystal ranges. Code 3 is the internal RC oscillator. Code 4 is the watchdog oscillator and code 5 is the external clock. The reserved codes 6 and 7 behave as a crystal.
- R3: For codes 4 and 5, `ready_o` becomes 1 at the FAST_CYCLES-th rising edge after the edge that samples `start_i`.
- R4: For code 3, `ready_o` becomes 1 at the edge that samples the RC_TICKS-th `ref_tick_i` pulse after the start edge. A tick sampled at the start edge itself is not counted.
- R5: For crystal codes, XTAL_CYCLES edges are counted first. After that, `ready_o` becomes 1 at the edge that samples the XTAL_TICKS-th tick strictly after the edge that ends the cycle count.
- R6: A start pulse during a wait clears both counters and restarts the wait from that edge, using the select code present at that edge.
- R7: The select code is captured only at a start edge. Any change on `sel_i` during a wait leaves that wait's length unchanged.
- R8: Once `ready_o` is 1 it stays 1 until the next start pulse. At the edge that samples that pulse, it goes to 0.
- R9: `clk_en_o` is 1 exactly when `ready_o` is 1 and `start_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Raw oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 3 | Clock-source select code |
| start_i | input | 1 | Start / wake pulse |
| ref_tick_i | input | 1 | Reference time strobe, one cycle wide |
| clk_en_o | output | 1 | Core clock enable |
| ready_o | output | 1 | Wait complete flag (registered) |

## Verification
The checker watches several properties on every cycle. It confirms that the clock enable never rises while a start pulse is present, and that a start always drops ready on the following edge. It also confirms that ready stays high until a start arrives and that the captured source class is stable through a wait. Two further checks are that a fast source never enters the timed phase and that a crystal wait reaches ready only from that phase. The exact wait lengths can only be shown by the bench scenarios: the cycle counts, the tick alignment of the windows, restarts in each phase, the reserved codes and select changes mid-wait. The bench sweeps every select code across every tick phase and compares each result with an arithmetic expectation.

// File: rtl/wkup_pkg.sv
package wkup_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [1:0] {
    CLS_XTAL = 2'd0,
    CLS_RC   = 2'd1,
    CLS_FAST = 2'd2
  } src_cls_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CYC  = 2'd1,
    ST_TIME = 2'd2,
    ST_DONE = 2'd3
  } state_e;
endpackage

// File: rtl/wkup_src_decode.sv
module wkup_src_decode
  import wkup_pkg::*;
(
  input  logic [SEL_W-1:0] sel_i,
  output src_cls_e         cls_o
);
  always_comb begin
    unique case (sel_i)
      3'd3:       cls_o = CLS_RC;
      3'd4, 3'd5: cls_o = CLS_FAST;
      default:    cls_o = CLS_XTAL; // crystal ranges and reserved codes
    endcase
  end
endmodule

// File: rtl/wkup_event_cnt.sv
module wkup_event_cnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic [W-1:0] limit_i,
  output logic [W-1:0] cnt_o,
  output logic         hit_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
  assign hit_o = inc_i && (cnt_q == limit_i);
endmodule

// File: rtl/wkup_delay_timer.sv
module wkup_delay_timer
  import wkup_pkg::*;
#(
  parameter int XTAL_CYCLES = 1024,
  parameter int FAST_CYCLES = 32,
  parameter int XTAL_TICKS  = 70,
  parameter int RC_TICKS    = 230
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             start_i,
  input  logic             ref_tick_i,
  output logic             clk_en_o,
  output logic             ready_o
);
  localparam int CYC_MAX = (XTAL_CYCLES > FAST_CYCLES) ? XTAL_CYCLES : FAST_CYCLES;
  localparam int TCK_MAX = (XTAL_TICKS > RC_TICKS) ? XTAL_TICKS : RC_TICKS;
  localparam int CYC_W   = $clog2(CYC_MAX + 1);
  localparam int TCK_W   = $clog2(TCK_MAX + 1);

  state_e   state_q;
  src_cls_e cls_q, cls_d;
  logic     ready_q;

  logic [CYC_W-1:0] cyc_cnt, cyc_lim;
  logic [TCK_W-1:0] tck_cnt, tck_lim;
  logic             cyc_hit, tck_hit;

  wkup_src_decode u_dec (
    .sel_i (sel_i),
    .cls_o (cls_d)
  );

  assign cyc_lim = (cls_q == CLS_XTAL) ? CYC_W'(XTAL_CYCLES - 1) : CYC_W'(FAST_CYCLES - 1);
  assign tck_lim = (cls_q == CLS_XTAL) ? TCK_W'(XTAL_TICKS - 1)  : TCK_W'(RC_TICKS - 1);

  wkup_event_cnt #(.W(CYC_W)) u_cyc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (start_i),
    .inc_i   (state_q == ST_CYC && !start_i),
    .limit_i (cyc_lim),
    .cnt_o   (cyc_cnt),
    .hit_o   (cyc_hit)
  );

  // tick window held clear while the cycle phase runs
  wkup_event_cnt #(.W(TCK_W)) u_tck (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (start_i || state_q == ST_CYC),
    .inc_i   (state_q == ST_TIME && ref_tick_i && !start_i),
    .limit_i (tck_lim),
    .cnt_o   (tck_cnt),
    .hit_o   (tck_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cls_q   <= CLS_XTAL;
      ready_q <= 1'b0;
    end else if (start_i) begin
      cls_q   <= cls_d;
      state_q <= (cls_d == CLS_RC) ? ST_TIME : ST_CYC;
      ready_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_CYC: if (cyc_hit) begin
          if (cls_q == CLS_XTAL) state_q <= ST_TIME;
          else begin
            state_q <= ST_DONE;
            ready_q <= 1'b1;
          end
        end
        ST_TIME: if (tck_hit) begin
          state_q <= ST_DONE;
          ready_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign ready_o  = ready_q;
  assign clk_en_o = ready_q && !start_i;
endmodule

// File: rtl/wkup_delay_timer_chk.sv
module wkup_delay_timer_chk
  import wkup_pkg::*;
#(
  parameter int CYC_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             ready_o,
  input logic             clk_en_o,
  input state_e           state_q,
  input src_cls_e         cls_q,
  input logic [CYC_W-1:0] cyc_cnt,
  input logic [CYC_W-1:0] cyc_lim
);
  // R9
  en_off_on_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !clk_en_o);

  // R8
  start_drops_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !ready_o);

  // R8
  ready_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !start_i) |=> ready_o);

  // R7
  class_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_CYC || state_q == ST_TIME) && !start_i) |=> $stable(cls_q));

  // R3
  fast_no_time_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls_q == CLS_FAST) |-> (state_q != ST_TIME));

  // R5
  xtal_ends_in_time_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ready_o) && cls_q == CLS_XTAL) |-> ($past(state_q) == ST_TIME));

  // R5
  cyc_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CYC) |-> (cyc_cnt <= cyc_lim));

  // R1
  idle_not_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !ready_o);
endmodule

bind wkup_delay_timer wkup_delay_timer_chk #(.CYC_W(CYC_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .ready_o  (ready_o),
  .clk_en_o (clk_en_o),
  .state_q  (state_q),
  .cls_q    (cls_q),
  .cyc_cnt  (cyc_cnt),
  .cyc_lim  (cyc_lim)
);

// File: tb/wkup_delay_timer_tb.sv
module wkup_delay_timer_tb;
  localparam int NX  = 16;
  localparam int NF  = 4;
  localparam int TX  = 3;
  localparam int TRC = 5;
  localparam int P   = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] sel_i = 3'd0;
  logic       start_i = 1'b0;
  logic       ref_tick_i = 1'b0;
  logic       clk_en_o, ready_o;

  int edge_n = 0;
  int n_chk = 0;
  int n_fail = 0;
  int e0 = 0;

  wkup_delay_timer #(
    .XTAL_CYCLES(NX), .FAST_CYCLES(NF), .XTAL_TICKS(TX), .RC_TICKS(TRC)
  ) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .start_i(start_i),
    .ref_tick_i(ref_tick_i), .clk_en_o(clk_en_o), .ready_o(ready_o)
  );

  always #4 clk_i = ~clk_i;

  always @(posedge clk_i) edge_n <= edge_n + 1;

  // tick present at edge e exactly when e % P == 0
  always @(negedge clk_i) ref_tick_i <= ((edge_n + 1) % P == 0);

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(posedge clk_i) begin
    if (edge_n == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (R1..) actual=%0d expected<150000", edge_n);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_edge(input int s, input int st);
    if (s == 4 || s == 5) return st + NF;
    if (s == 3) return (st / P + TRC) * P;
    return ((st + NX) / P + TX) * P;
  endfunction

  task automatic do_start(input logic [2:0] s);
    @(negedge clk_i);
    sel_i = s;
    start_i = 1'b1;
    e0 = edge_n + 1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_ready(output int got);
    got = -1;
    for (int i = 0; i < 2000; i++) begin
      if (ready_o) begin
        got = edge_n;
        break;
      end
      @(negedge clk_i);
    end
  endtask

  task automatic run_one(input logic [2:0] s, input string req);
    int got, exp;
    do_start(s);
    check(ready_o == 1'b0 && clk_en_o == 1'b0, "R8 low after start", ready_o, 0);
    exp = exp_edge(s, e0);
    wait_ready(got);
    check(got == exp, req, got, exp);
    check(clk_en_o == 1'b1, "R9 enable follows ready", clk_en_o, 1);
  endtask

  initial begin
    int got, exp;
    #1;
    check(ready_o == 0 && clk_en_o == 0, "R1 in reset", ready_o, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (20) @(negedge clk_i);
    check(ready_o == 0 && clk_en_o == 0, "R1 idle after reset", ready_o, 0);

    // sweep all codes over every tick phase
    for (int ph = 0; ph < P; ph++) begin
      for (int s = 0; s < 8; s++) begin
        repeat (ph) @(negedge clk_i);
        if (s == 3)              run_one(3'(s), "R4 rc wait");
        else if (s == 4 || s == 5) run_one(3'(s), "R3 fast wait");
        else if (s >= 6)         run_one(3'(s), "R2 reserved as crystal");
        else                     run_one(3'(s), "R5 crystal wait");
      end
    end

    // R8: ready holds while idle and sel toggles
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_i);
      sel_i = 3'(i);
    end
    check(ready_o == 1'b1, "R8 ready holds", ready_o, 1);

    // R9: enable drops in the start cycle itself
    @(negedge clk_i);
    sel_i = 3'd4;
    start_i = 1'b1;
    #1;
    check(clk_en_o == 1'b0 && ready_o == 1'b1, "R9 enable off with start", clk_en_o, 0);
    e0 = edge_n + 1;
    @(negedge clk_i);
    start_i = 1'b0;
    wait_ready(got);
    check(got == e0 + NF, "R3 fast after start from ready", got, e0 + NF);

    // R6: restart during cycle phase with another source
    do_start(3'd0);
    repeat (7) @(negedge clk_i);
    do_start(3'd4);
    exp = exp_edge(4, e0);
    wait_ready(got);
    check(got == exp, "R6 restart in cycle phase", got, exp);

    // R6: restart during timed phase
    do_start(3'd3);
    repeat (6) @(negedge clk_i);
    do_start(3'd5);
    exp = exp_edge(5, e0);
    wait_ready(got);
    check(got == exp, "R6 restart in timed phase", got, exp);

    // R6: restart crystal during its timed phase
    do_start(3'd1);
    repeat (NX + 3) @(negedge clk_i);
    check(ready_o == 1'b0, "R5 not ready early", ready_o, 0);
    do_start(3'd2);
    exp = exp_edge(2, e0);
    wait_ready(got);
    check(got == exp, "R6 restart crystal", got, exp);

    // R7: select change mid-wait ignored
    do_start(3'd4);
    sel_i = 3'd0;
    exp = exp_edge(4, e0);
    wait_ready(got);
    check(got == exp, "R7 fast with sel changed", got, exp);

    do_start(3'd1);
    sel_i = 3'd4;
    exp = exp_edge(1, e0);
    wait_ready(got);
    check(got == exp, "R7 crystal with sel changed", got, exp);

    do_start(3'd3);
    sel_i = 3'd5;
    exp = exp_edge(3, e0);
    wait_ready(got);
    check(got == exp, "R7 rc with sel changed", got, exp);

    // R1: reset mid-wait returns to low outputs
    do_start(3'd0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check(ready_o == 0 && clk_en_o == 0, "R1 reset mid-wait", ready_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (NX + TX * P + 10) @(negedge clk_i);
    check(ready_o == 0, "R1 no ready without start", ready_o, 0);

    summary();
    $finish;
  end
endmodule